// File: doc/BRIEF.md
# Return-from-interrupt state restore unit

This block computes the machine state that takes effect when a return-from-interrupt instruction completes. It takes the 64-bit machine state register in force now, the saved status word (SRR1) and the saved return address (SRR0). From them it forms the new machine state word and the address of the next instruction. Most bits of the new state come straight from the saved status word. A few are merged under rules of their own: the hypervisor flag, the machine-check enable, the interrupt and translation enables, and the three-bit transaction-state field.

The execution stage pulses `issue_i` for one cycle when the instruction executes. One clock later the results are in output registers, with a valid flag for each result. The registers keep their contents until the next issue. Deciding whether the instruction is permitted and handshaking with the pipeline are done elsewhere.

Bit numbers in the requirements are big-endian (bit 0 is the MSB). Big-endian bit k is vector index 63-k.

Top module: `rfi_restore_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `msr_o`, `nia_o`, `msr_vld_o` and `nia_vld_o` are all zero.
- R2: `msr_vld_o` and `nia_vld_o` are both 1 in the cycle after a cycle with `issue_i` high, and both 0 in the cycle after a cycle with `issue_i` low.
- R3: After an issue, `nia_o` equals `srr0_i` with its two least significant bits (vector indices 1 and 0) cleared.
- R4: After an issue, new hypervisor bit 3 (index 60) = current bit 3 AND saved bit 3.
- R5: After an issue, new machine-check-enable bit 51 (index 12) = saved bit 51 when current bit 3 is 1, otherwise current bit 51.
- R6: After an issue, the new enable bits 48 (index 15), 58 (index 5) and 59 (index 4) each equal the saved copy of that bit OR saved problem-state bit 49 (index 14).
- R7: After an issue, the new field bits 29..31 (indices 34..32, read MSB first) take the saved field unless the current field is 0b010 and the saved field is 0b000. In that case they keep the current value.
- R8: After an issue, every other bit of the new state equals the same bit of `srr1_i`. This includes problem-state bit 49.
- R9: In a cycle with `issue_i` low, `msr_o` and `nia_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Return-from-interrupt executes this cycle |
| cur_msr_i | input | 64 | Machine state word in force now |
| srr0_i | input | 64 | Saved return address |
| srr1_i | input | 64 | Saved machine status word |
| msr_o | output | 64 | Restored machine state word |
| msr_vld_o | output | 1 | `msr_o` updated by the last cycle's issue |
| nia_o | output | 64 | Next instruction address |
| nia_vld_o | output | 1 | `nia_o` updated by the last cycle's issue |

## Verification
There is only one register stage, so a merge fault shows up in `msr_o` in the cycle right after the issue that triggered it. The fault appears only in the bit group whose rule is wrong. For that reason the bench compares each bit group on its own, on every cycle. The stimulus covers both hypervisor states, problem state set and clear, and all four combinations of the transaction-field guard. A hold fault shows only after an idle cycle, as a change in `msr_o` or `nia_o` that no issue caused. Idle cycles are therefore mixed in among the issues.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int MSR_W = 64;
  // vector indices of big-endian bit numbers (index = 63 - be)
  localparam int HV_IX  = MSR_W - 1 - 3;
  localparam int ME_IX  = MSR_W - 1 - 51;
  localparam int EE_IX  = MSR_W - 1 - 48;
  localparam int PR_IX  = MSR_W - 1 - 49;
  localparam int IR_IX  = MSR_W - 1 - 58;
  localparam int DR_IX  = MSR_W - 1 - 59;
  localparam int TS_HI  = MSR_W - 1 - 29;
  localparam int TS_LO  = MSR_W - 1 - 31;
  localparam int TS_W   = TS_HI - TS_LO + 1;
  localparam logic [TS_W-1:0] TS_GUARD_CUR = 3'b010;
  localparam logic [TS_W-1:0] TS_GUARD_SAV = 3'b000;
endpackage

// File: rtl/rfi_msr_merge.sv
module rfi_msr_merge
  import rfi_pkg::*;
(
  input  logic [MSR_W-1:0] cur_i,
  input  logic [MSR_W-1:0] sav_i,
  output logic [MSR_W-1:0] msr_o
);
  logic             pr_force;
  logic             ts_keep;

  assign pr_force = sav_i[PR_IX];
  assign ts_keep  = (cur_i[TS_HI:TS_LO] == TS_GUARD_CUR) &&
                    (sav_i[TS_HI:TS_LO] == TS_GUARD_SAV);

  always_comb begin
    msr_o = sav_i;
    msr_o[HV_IX] = cur_i[HV_IX] & sav_i[HV_IX];
    msr_o[ME_IX] = cur_i[HV_IX] ? sav_i[ME_IX] : cur_i[ME_IX];
    msr_o[EE_IX] = sav_i[EE_IX] | pr_force;
    msr_o[IR_IX] = sav_i[IR_IX] | pr_force;
    msr_o[DR_IX] = sav_i[DR_IX] | pr_force;
    if (ts_keep)
      msr_o[TS_HI:TS_LO] = cur_i[TS_HI:TS_LO];
  end
endmodule

// File: rtl/rfi_nia_align.sv
module rfi_nia_align #(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);
  assign addr_o = addr_i & ~LOW_MASK;
endmodule

// File: rtl/rfi_out_reg.sv
module rfi_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/rfi_restore_unit.sv
module rfi_restore_unit
  import rfi_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [MSR_W-1:0]  cur_msr_i,
  input  logic [ADDR_W-1:0] srr0_i,
  input  logic [MSR_W-1:0]  srr1_i,
  output logic [MSR_W-1:0]  msr_o,
  output logic              msr_vld_o,
  output logic [ADDR_W-1:0] nia_o,
  output logic              nia_vld_o
);
  logic [MSR_W-1:0]  msr_next;
  logic [ADDR_W-1:0] nia_next;

  rfi_msr_merge u_merge (
    .cur_i (cur_msr_i),
    .sav_i (srr1_i),
    .msr_o (msr_next)
  );

  rfi_nia_align #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
    .addr_i (srr0_i),
    .addr_o (nia_next)
  );

  rfi_out_reg #(.W(MSR_W)) u_msr_reg (
    .clk (clk), .rst (rst), .load_i (issue_i),
    .d_i (msr_next), .q_o (msr_o), .vld_o (msr_vld_o)
  );

  rfi_out_reg #(.W(ADDR_W)) u_nia_reg (
    .clk (clk), .rst (rst), .load_i (issue_i),
    .d_i (nia_next), .q_o (nia_o), .vld_o (nia_vld_o)
  );

  AST_VALID_PAIR: assert property (@(posedge clk) disable iff (rst)
    msr_vld_o == nia_vld_o); // R2
  AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> msr_vld_o); // R2
  AST_NIA_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    nia_vld_o |-> (nia_o[ALIGN_BITS-1:0] == '0)); // R3
  AST_HV_AND: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> msr_o[HV_IX] == ($past(cur_msr_i[HV_IX]) & $past(srr1_i[HV_IX]))); // R4
  AST_ME_SELECT: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !cur_msr_i[HV_IX]) |=> msr_o[ME_IX] == $past(cur_msr_i[ME_IX])); // R5
  AST_PR_FORCE: assert property (@(posedge clk) disable iff (rst)
    (issue_i && srr1_i[PR_IX]) |=> (msr_o[EE_IX] && msr_o[IR_IX] && msr_o[DR_IX])); // R6
  AST_TS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (issue_i && cur_msr_i[TS_HI:TS_LO] == TS_GUARD_CUR && srr1_i[TS_HI:TS_LO] == TS_GUARD_SAV)
      |=> msr_o[TS_HI:TS_LO] == TS_GUARD_CUR); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> ($stable(msr_o) && $stable(nia_o))); // R9
endmodule

// File: tb/rfi_restore_unit_tb_top.sv
module rfi_restore_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [63:0] cur = '0, s0 = '0, s1 = '0;
  logic [63:0] msr_o, nia_o;
  logic        msr_vld_o, nia_vld_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] e_msr = '0, e_nia = '0;
  logic        e_vld = 1'b0;

  always #5 clk = ~clk;

  rfi_restore_unit dut_i (
    .clk(clk), .rst(rst), .issue_i(issue), .cur_msr_i(cur),
    .srr0_i(s0), .srr1_i(s1), .msr_o(msr_o), .msr_vld_o(msr_vld_o),
    .nia_o(nia_o), .nia_vld_o(nia_vld_o)
  );

  function automatic int ix(input int be);
    return 63 - be;
  endfunction

  function automatic logic [63:0] ref_msr(input logic [63:0] c, input logic [63:0] s);
    logic [63:0] r;
    logic [2:0] tc, ts;
    r = s;
    r[ix(3)]  = c[ix(3)] && s[ix(3)];
    r[ix(51)] = c[ix(3)] ? s[ix(51)] : c[ix(51)];
    foreach (r[k]) if (k == ix(48) || k == ix(58) || k == ix(59)) r[k] = s[k] | s[ix(49)];
    tc = {c[ix(29)], c[ix(30)], c[ix(31)]};
    ts = {s[ix(29)], s[ix(30)], s[ix(31)]};
    if (tc == 3'b010 && ts == 3'b000) begin
      r[ix(29)] = tc[2]; r[ix(30)] = tc[1]; r[ix(31)] = tc[0];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] grp(input logic [63:0] v, input int g);
    logic [63:0] m;
    m = '0;
    case (g)
      0: m[ix(3)] = 1'b1;
      1: m[ix(51)] = 1'b1;
      2: begin m[ix(48)] = 1'b1; m[ix(58)] = 1'b1; m[ix(59)] = 1'b1; end
      3: begin m[ix(29)] = 1'b1; m[ix(30)] = 1'b1; m[ix(31)] = 1'b1; end
      default: begin
        m = '1;
        m[ix(3)] = 1'b0; m[ix(51)] = 1'b0; m[ix(48)] = 1'b0; m[ix(58)] = 1'b0;
        m[ix(59)] = 1'b0; m[ix(29)] = 1'b0; m[ix(30)] = 1'b0; m[ix(31)] = 1'b0;
      end
    endcase
    return v & m;
  endfunction

  // apply inputs at negedge, advance one clock, update model, compare at negedge
  task automatic step(input logic iss, input logic [63:0] c, input logic [63:0] a, input logic [63:0] s);
    issue = iss; cur = c; s0 = a; s1 = s;
    @(posedge clk);
    e_vld = iss;
    if (iss) begin
      e_msr = ref_msr(c, s);
      e_nia = {a[63:2], 2'b00};
    end
    @(negedge clk);
    chk("R2 valid msr", {63'd0, msr_vld_o}, {63'd0, e_vld});
    chk("R2 valid nia", {63'd0, nia_vld_o}, {63'd0, e_vld});
    chk(iss ? "R3 nia" : "R9 nia hold", nia_o, e_nia);
    chk(iss ? "R4 hv" : "R9 msr hold", grp(msr_o, 0), grp(e_msr, 0));
    chk("R5 me", grp(msr_o, 1), grp(e_msr, 1));
    chk("R6 ee/ir/dr", grp(msr_o, 2), grp(e_msr, 2));
    chk("R7 ts field", grp(msr_o, 3), grp(e_msr, 3));
    chk("R8 plain copy", grp(msr_o, 4), grp(e_msr, 4));
  endtask

  function automatic logic [63:0] with_ts(input logic [63:0] v, input logic [2:0] t);
    logic [63:0] r;
    r = v;
    r[ix(29)] = t[2]; r[ix(30)] = t[1]; r[ix(31)] = t[0];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset msr", msr_o, '0);
    chk("R1 reset nia", nia_o, '0);
    chk("R1 reset valid", {62'd0, msr_vld_o, nia_vld_o}, '0);
    rst = 1'b0;
    step(1'b0, '1, '1, '1); // R1 first cycle out of reset: still zero
    // R4/R5 both hypervisor states
    step(1'b1, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_1237, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_4003, 64'h1000_0000_0000_0000);
    step(1'b1, 64'h1000_0000_0000_0000, 64'hDEAD_BEEF_0000_0001, 64'h0000_0000_0000_0000);
    // R6 problem state forcing, and cleared
    step(1'b1, '0, 64'h8, 64'h0000_0000_0000_4000);
    step(1'b1, '0, 64'hC, 64'h0000_0000_0000_8030);
    step(1'b0, '1, '1, '1); // R9 idle must hold
    step(1'b0, 64'h55, 64'h77, 64'h99);
    // R7 guard combinations
    step(1'b1, with_ts('0, 3'b010), 64'h10, with_ts('0, 3'b000));
    step(1'b1, with_ts('0, 3'b010), 64'h14, with_ts('0, 3'b001));
    step(1'b1, with_ts('0, 3'b000), 64'h18, with_ts('1, 3'b000));
    step(1'b1, with_ts('1, 3'b110), 64'h1B, with_ts('0, 3'b000));
    step(1'b1, with_ts('1, 3'b010), 64'h1F, with_ts(64'h0123_4567_89AB_CDEF, 3'b000));
    for (int i = 0; i < 300; i++) begin
      logic [63:0] c, a, s;
      c = {$urandom, $urandom}; a = {$urandom, $urandom}; s = {$urandom, $urandom};
      if (i % 7 == 0) begin c = with_ts(c, 3'b010); s = with_ts(s, 3'b000); end
      step(($urandom % 4) != 0, c, a, s);
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 re-reset msr", msr_o, '0);
    chk("R1 re-reset valid", {63'd0, msr_vld_o}, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule